// File: doc/BRIEF.md
# GPIO Port Data Register Bank

This block is the data path of a 32-pin general-purpose I/O port. Software reaches it over a simple synchronous register bus with a 3-bit word address. It holds an output value register and a direction register. The output value can be loaded whole, or changed bit by bit through three write-only mask words: set, clear and toggle. Any subset of pins can therefore change without a read-modify-write sequence.

On the pin side the block drives the output value and one output enable per pin. A direction bit of 1 makes its pin an output. It also samples the pin inputs through a two-flop synchronizer. The synchronized levels appear on a port and in a read-only input word.

The bus allows one access per cycle, so a whole-word load and a mask write can never land in the same cycle. A write takes effect on the clock edge that samples it. Read data is registered and is valid in the cycle after the read request.

Top module: `gpio_bank`

## Requirements
- R1: A synchronous active-low reset clears the output value, the direction (all pins are inputs, pin_oe = 0), the synchronizer and bus_rdata.
- R2: A write to word 0 (output value) replaces all 32 output bits with bus_wdata. A read of word 0 returns that value.
- R3: A write to word 1 (set) forces to 1 each output bit whose mask bit is 1 and leaves the other output bits unchanged.
- R4: A write to word 2 (clear) forces to 0 each output bit whose mask bit is 1 and leaves the other output bits unchanged.
- R5: A write to word 3 (toggle) inverts each output bit whose mask bit is 1 and leaves the other output bits unchanged.
- R6: A write to word 5 (direction) loads the direction register. pin_oe equals the direction register, where bit = 1 means output. A read of word 5 returns the register.
- R7: Reads of words 1, 2 and 3, and of the unmapped words 6 and 7, return zero.
- R8: Word 4 (input) is read-only. A write to it changes neither the output value nor the direction.
- R9: A pin_in change appears on pin_in_sync two clock edges later. A read of word 4 returns pin_in_sync.
- R10: bus_rdata is registered. It carries the read value in the cycle after the read request and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address (0 value, 1 set, 2 clear, 3 toggle, 4 input, 5 direction) |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin |
| pin_in_sync | output | 32 | Synchronized pin levels |

## Verification
A vector table steps through a chain of whole-word loads and set, clear and toggle masks. The masks overlap bits that are already 1, bits that are already 0 and bits the previous step just changed. This separates a mask that merges correctly from one that overwrites, inverts the wrong way or uses the wrong polarity. Zero and all-ones masks show that untouched bits are kept and that a full-width operation works. A write to the input word inside the chain shows that the read-only word cannot alter the output value. Directed tests cover the reset state, direction patterns, reads of the mask and unmapped words, and the exact edge at which an input change reaches the synchronizer output.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants and the word-address encoding of the GPIO bank.
// Assumes a 3-bit word address; the word numbers are fixed by the register bus.
package gpio_bank_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        WORD_VALUE = 3'd0,
        WORD_SET   = 3'd1,
        WORD_CLR   = 3'd2,
        WORD_TGL   = 3'd3,
        WORD_IN    = 3'd4,
        WORD_DIR   = 3'd5
    } word_e;
endpackage

// File: rtl/gpio_out_regs.sv
// Module: output value and direction registers with per-bit set/clear/toggle.
// Assumes at most one write per cycle (wr_en qualifies word and data).
module gpio_out_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  word_e           word,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] value_q,
    output logic [PINS-1:0] dir_q
);
    logic [PINS-1:0] value_d;

    // Per-bit next value: pick the operation the addressed word selects.
    for (genvar b = 0; b < PINS; b++) begin : g_bit
        always_comb begin
            value_d[b] = value_q[b];
            if (wr_en) begin
                unique case (word)
                    WORD_VALUE: value_d[b] = wdata[b];
                    WORD_SET:   value_d[b] = value_q[b] | wdata[b];
                    WORD_CLR:   value_d[b] = value_q[b] & ~wdata[b];
                    WORD_TGL:   value_d[b] = value_q[b] ^ wdata[b];
                    default:    value_d[b] = value_q[b];
                endcase
            end
        end
    end

    // Output value register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    // Direction register, loaded only by a direction-word write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= '0;
        else if (wr_en && word == WORD_DIR)  dir_q <= wdata;
    end

    // R1: reset leaves every pin an input with a zero value.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (value_q == '0 && dir_q == '0));
    // R3: set mask forces ones and keeps other bits.
    a_r3_set_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == WORD_SET) |=>
        value_q == ($past(value_q) | $past(wdata)));
    // R4: clear mask forces zeros and keeps other bits.
    a_r4_clear_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == WORD_CLR) |=>
        value_q == ($past(value_q) & ~$past(wdata)));
    // R5: toggle mask inverts selected bits.
    a_r5_toggle_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == WORD_TGL) |=>
        value_q == ($past(value_q) ^ $past(wdata)));
    // R6: direction word loads the direction register.
    a_r6_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == WORD_DIR) |=> dir_q == $past(wdata));
    // R8: a write to the input word touches no register.
    a_r8_input_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == WORD_IN) |=> ($stable(value_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-flop synchronizer for the asynchronous pin inputs.
// Assumes each pin is an independent level; no bus coherence across pins.
module gpio_in_sync #(
    parameter int unsigned PINS   = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_sync
);
    logic [PINS-1:0] stage_q [STAGES];

    // First flop captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pin_in;
    end

    // Remaining flops form the settling chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign pin_sync = stage_q[STAGES-1];

    // Cycles since reset, saturating at 2, so the 2-cycle check is valid.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)           warm_q <= '0;
        else if (warm_q != 2) warm_q <= warm_q + 2'd1;
    end

    // R9: output follows the pin two edges later (default depth).
    a_r9_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGES == 2 && warm_q == 2) |-> pin_sync == $past(pin_in, 2));
endmodule

// File: rtl/gpio_rd_mux.sv
// Module: registered read-data selector for the register bus.
// Assumes rd_en is asserted only for read accesses; returns zero otherwise.
module gpio_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  word_e           word,
    input  logic [PINS-1:0] value_q,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] pin_sync,
    output logic [PINS-1:0] rdata
);
    // Capture the addressed word, or zero when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            case (word)
                WORD_VALUE: rdata <= value_q;
                WORD_IN:    rdata <= pin_sync;
                WORD_DIR:   rdata <= dir_q;
                default:    rdata <= '0;
            endcase
        end else rdata <= '0;
    end

    // R7: mask words and unmapped words read zero.
    a_r7_mask_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (word == WORD_SET || word == WORD_CLR || word == WORD_TGL))
        |=> rdata == '0);
    // R10: no read request gives zero read data next cycle.
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);
endmodule

// File: rtl/gpio_bank.sv
// Module: 32-pin GPIO data register bank (top level).
// Decodes one bus access per cycle into the output/direction registers and the
// read mux; drives pins and exposes the synchronized inputs.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS        = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_in_sync
);
    logic  wr_en;
    logic  rd_en;
    word_e word;
    logic [PINS-1:0] value_q;
    logic [PINS-1:0] dir_q;

    // Split the single access into write and read strobes.
    always_comb begin
        wr_en = bus_sel & bus_we;
        rd_en = bus_sel & ~bus_we;
        word  = word_e'(bus_addr);
    end

    gpio_out_regs #(.PINS(PINS)) u_out (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word(word),
        .wdata(bus_wdata), .value_q(value_q), .dir_q(dir_q)
    );

    gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_in_sync)
    );

    gpio_rd_mux #(.PINS(PINS)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .word(word),
        .value_q(value_q), .dir_q(dir_q), .pin_sync(pin_in_sync),
        .rdata(bus_rdata)
    );

    assign pin_out = value_q;
    assign pin_oe  = dir_q;

    // R2: a whole-word write shows on the pins at the next edge.
    a_r2_value_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == WORD_VALUE) |=> pin_out == $past(bus_wdata));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pin_in_sync;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    gpio_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_in_sync(pin_in_sync)
    );

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] expect_out;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 32'hA5A5_00FF, 32'hA5A5_00FF},  // R2 load
        '{3'd1, 32'h0000_FF00, 32'hA5A5_FFFF},  // R3 set
        '{3'd2, 32'h0000_00F0, 32'hA5A5_FF0F},  // R4 clear
        '{3'd3, 32'hFFFF_0000, 32'h5A5A_FF0F},  // R5 toggle
        '{3'd1, 32'h0000_0000, 32'h5A5A_FF0F},  // R3 empty set mask
        '{3'd2, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 full clear
        '{3'd3, 32'h8000_0001, 32'h8000_0001},  // R5 edge bits
        '{3'd0, 32'h1234_5678, 32'h1234_5678},  // R2 reload
        '{3'd4, 32'hFFFF_FFFF, 32'h1234_5678}   // R8 input word ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;

        // R2-R5, R8 vector walk
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i].addr, VEC[i].data);
            check($sformatf("vec%0d pin_out (R2/R3/R4/R5/R8)", i), pin_out, VEC[i].expect_out);
            bus_read(3'd0, rd);
            check($sformatf("vec%0d readback R2", i), rd, VEC[i].expect_out);
        end

        // R10: rdata returns to zero the cycle after a read
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'h0);

        // R6: direction
        bus_write(3'd5, 32'hF0F0_1234);
        check("R6 pin_oe", pin_oe, 32'hF0F0_1234);
        bus_read(3'd5, rd);
        check("R6 readback", rd, 32'hF0F0_1234);
        check("R6 value kept", pin_out, 32'h1234_5678);
        bus_write(3'd4, 32'h0);
        check("R8 dir kept", pin_oe, 32'hF0F0_1234);

        // R7: mask and unmapped words read zero
        for (int a = 1; a <= 7; a++) begin
            if (a == 4 || a == 5) continue;
            bus_read(a[2:0], rd);
            check($sformatf("R7 word %0d", a), rd, 32'h0);
        end

        // R9: two-edge synchronizer
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R9 after 1 edge", pin_in_sync, 32'h0);
        @(negedge clk);
        check("R9 after 2 edges", pin_in_sync, 32'hDEAD_BEEF);
        bus_read(3'd4, rd);
        check("R9 input word", rd, 32'hDEAD_BEEF);

        // R1: reset after activity clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset pin_out", pin_out, 32'h0);
        check("R1 reset pin_oe", pin_oe, 32'h0);
        check("R1 reset sync", pin_in_sync, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule